// File: doc/BRIEF.md
# Zero-Count Lane Inversion Codec

This block sits between a 64-bit datapath and a wide shared bus on which driving a line low costs power. On the transmit side it splits each word into four 16-bit lanes, counts the zeros in each lane, and inverts every lane whose zero count is above half its width. Alongside the word it drives one active-low flag per lane, so a flag at 0 tells the far end that the lane arrived inverted. Encoded data and flags leave together from one output register, so a flag never reaches the bus a cycle before or after its lane.

On the receive side the block takes a word and its four flags, inverts back every lane whose flag is low, and passes the restored word on. Both directions use a valid/ready handshake. A transmit-enable input parks the transmit side: while it is low, nothing is accepted and the bus side shows the idle pattern (all data ones, all flags high). A parameter selects whether the receive path is registered or purely combinational.

Top module: `dbi_codec`

## Requirements
- R1: The word is handled as four independent 16-bit lanes; flag bit i covers data bits [16*i+15:16*i], and the decision for one lane never depends on the bits of another.
- R2: A transmitted lane with 9 or more zero bits is sent bitwise inverted, and its flag is driven 0.
- R3: A transmitted lane with 8 or fewer zero bits is sent unchanged, and its flag is driven 1.
- R4: While the transmit output is valid, no lane of its data carries more than 8 zero bits.
- R5: A word accepted on the transmit input (valid and ready both 1 at a rising edge) appears on the transmit output, with its flags, right after that same edge.
- R6: After reset, and whenever the transmit output is not valid, the transmit data is all ones and all four flags are 1.
- R7: While transmit enable is 0, the transmit input ready is 0, no word is accepted, and the transmit output is idle as in R6.
- R8: On receive, each lane whose flag is 0 is inverted and each lane whose flag is 1 is passed unchanged.
- R9: While the transmit output is valid and its ready is 0 (with enable 1), data, flags and valid hold steady.
- R10: With the receive stage registered (RX_PIPE = 1, the default), a word accepted on the receive input appears restored on the receive output right after that edge, the receive input ready is 0 while a held word waits, and a held word stays stable until taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tx_en | input | 1 | Transmit enable; 0 parks the transmit side |
| tx_in_valid | input | 1 | Transmit source has a word |
| tx_in_ready | output | 1 | Transmit side can take a word |
| tx_in_data | input | 64 | Plain word to transmit |
| tx_out_valid | output | 1 | Encoded word is on the bus side |
| tx_out_ready | input | 1 | Bus side takes the encoded word |
| tx_out_data | output | 64 | Encoded word |
| tx_out_flag_n | output | 4 | Per-lane inversion flags, 0 = lane inverted |
| rx_in_valid | input | 1 | Bus side presents a received word |
| rx_in_ready | output | 1 | Receive side can take a word |
| rx_in_data | input | 64 | Received encoded word |
| rx_in_flag_n | input | 4 | Received per-lane flags, 0 = lane inverted |
| rx_out_valid | output | 1 | Restored word is available |
| rx_out_ready | input | 1 | Consumer takes the restored word |
| rx_out_data | output | 64 | Restored word |

## Verification
The bench drives lanes holding exactly 8 and exactly 9 zeros, since a threshold off by one, or a compare of "at least 8", would invert the 8-zero lane or leave the 9-zero lane plain and break the zero-count bound. A word mixing all four lane kinds catches a swapped flag index or lane slice, which would invert the wrong 16 bits, and all-zero and all-one words catch a flipped flag polarity that would make every round trip come back inverted. Stalls on both outputs and a dropped enable show whether a held word changes under backpressure or a parked transmitter still takes words or leaks non-idle data.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
    localparam int LANE_W  = 16;
    localparam int LANES   = 4;
    localparam int DATA_W  = LANE_W * LANES;
    localparam int ZC_W    = $clog2(LANE_W + 1);
    localparam int FLIP_AT = LANE_W / 2 + 1;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [LANES-1:0]  flag_t;
    typedef logic [LANE_W-1:0] lane_t;
    typedef logic [ZC_W-1:0]   count_t;

    typedef struct packed {
        logic  valid;
        flag_t flag_n;
        word_t data;
    } tx_beat_t;

    localparam tx_beat_t TX_IDLE = '{valid: 1'b0, flag_n: '1, data: '1};

    function automatic count_t zeros_in(lane_t v);
        count_t n;
        n = '0;
        for (int b = 0; b < LANE_W; b++) begin
            n = n + count_t'(!v[b]);
        end
        return n;
    endfunction
endpackage

// File: rtl/dbi_lane_flip.sv
module dbi_lane_flip
    import dbi_pkg::*;
(
    input  lane_t lane_in,
    output lane_t lane_out,
    output logic  flip
);
    count_t zc;

    always_comb begin
        zc       = zeros_in(lane_in);
        flip     = (zc >= count_t'(FLIP_AT));
        lane_out = flip ? ~lane_in : lane_in;
    end
endmodule

// File: rtl/dbi_tx.sv
module dbi_tx
    import dbi_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  in_valid,
    output logic  in_ready,
    input  word_t in_data,
    output logic  out_valid,
    input  logic  out_ready,
    output word_t out_data,
    output flag_t out_flag_n
);
    word_t    enc;
    flag_t    flip;
    tx_beat_t beat_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dbi_lane_flip u_flip (
            .lane_in  (in_data[g*LANE_W +: LANE_W]),
            .lane_out (enc[g*LANE_W +: LANE_W]),
            .flip     (flip[g])
        );
    end

    assign in_ready = en && (!beat_q.valid || out_ready);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            beat_q <= TX_IDLE;
        end else if (in_valid && in_ready) begin
            beat_q <= '{valid: 1'b1, flag_n: ~flip, data: enc};
        end else if (out_ready) begin
            beat_q <= TX_IDLE;
        end
    end

    assign out_valid  = beat_q.valid;
    assign out_data   = beat_q.data;
    assign out_flag_n = beat_q.flag_n;
endmodule

// File: rtl/dbi_rx.sv
module dbi_rx
    import dbi_pkg::*;
#(
    parameter bit RX_PIPE = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    output logic  in_ready,
    input  word_t in_data,
    input  flag_t in_flag_n,
    output logic  out_valid,
    input  logic  out_ready,
    output word_t out_data
);
    word_t restored;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign restored[g*LANE_W +: LANE_W] = in_flag_n[g]
            ? in_data[g*LANE_W +: LANE_W]
            : ~in_data[g*LANE_W +: LANE_W];
    end

    if (RX_PIPE) begin : g_pipe
        logic  valid_q;
        word_t data_q;

        assign in_ready = !valid_q || out_ready;

        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q <= 1'b0;
                data_q  <= '0;
            end else if (in_valid && in_ready) begin
                valid_q <= 1'b1;
                data_q  <= restored;
            end else if (out_ready) begin
                valid_q <= 1'b0;
            end
        end

        assign out_valid = valid_q;
        assign out_data  = data_q;
    end else begin : g_flow
        logic unused_clk_rst;
        assign unused_clk_rst = clk ^ rst;
        assign in_ready  = out_ready;
        assign out_valid = in_valid;
        assign out_data  = restored;
    end
endmodule

// File: rtl/dbi_codec.sv
module dbi_codec
    import dbi_pkg::*;
#(
    parameter bit RX_PIPE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic              tx_in_valid,
    output logic              tx_in_ready,
    input  logic [DATA_W-1:0] tx_in_data,
    output logic              tx_out_valid,
    input  logic              tx_out_ready,
    output logic [DATA_W-1:0] tx_out_data,
    output logic [LANES-1:0]  tx_out_flag_n,
    input  logic              rx_in_valid,
    output logic              rx_in_ready,
    input  logic [DATA_W-1:0] rx_in_data,
    input  logic [LANES-1:0]  rx_in_flag_n,
    output logic              rx_out_valid,
    input  logic              rx_out_ready,
    output logic [DATA_W-1:0] rx_out_data
);
    dbi_tx u_tx (
        .clk        (clk),
        .rst        (rst),
        .en         (tx_en),
        .in_valid   (tx_in_valid),
        .in_ready   (tx_in_ready),
        .in_data    (tx_in_data),
        .out_valid  (tx_out_valid),
        .out_ready  (tx_out_ready),
        .out_data   (tx_out_data),
        .out_flag_n (tx_out_flag_n)
    );

    dbi_rx #(.RX_PIPE(RX_PIPE)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (rx_in_valid),
        .in_ready  (rx_in_ready),
        .in_data   (rx_in_data),
        .in_flag_n (rx_in_flag_n),
        .out_valid (rx_out_valid),
        .out_ready (rx_out_ready),
        .out_data  (rx_out_data)
    );
endmodule

// File: rtl/dbi_codec_chk.sv
module dbi_codec_chk
    import dbi_pkg::*;
#(
    parameter bit RX_PIPE = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              tx_en,
    input logic              tx_in_valid,
    input logic              tx_in_ready,
    input logic [DATA_W-1:0] tx_in_data,
    input logic              tx_out_valid,
    input logic              tx_out_ready,
    input logic [DATA_W-1:0] tx_out_data,
    input logic [LANES-1:0]  tx_out_flag_n,
    input logic              rx_in_valid,
    input logic              rx_in_ready,
    input logic              rx_out_valid,
    input logic              rx_out_ready,
    input logic [DATA_W-1:0] rx_out_data
);
    logic tx_take;
    assign tx_take = tx_in_valid && tx_in_ready;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // R4: encoded lane zero count bounded
        a_r4_low_bits_bounded: assert property (@(posedge clk) disable iff (rst)
            tx_out_valid |-> ($countones(~tx_out_data[g*LANE_W +: LANE_W]) < FLIP_AT));
        // R2 / R3: flag follows zero count of the accepted lane
        a_r2_flag_matches_count: assert property (@(posedge clk) disable iff (rst)
            tx_take |=> (tx_out_flag_n[g] ==
                ($countones(~$past(tx_in_data[g*LANE_W +: LANE_W])) < FLIP_AT)));
    end

    a_r5_accept_shows_next: assert property (@(posedge clk) disable iff (rst)
        tx_take |=> tx_out_valid);

    a_r6_idle_pattern: assert property (@(posedge clk) disable iff (rst)
        !tx_out_valid |-> (tx_out_flag_n == '1 && tx_out_data == '1));

    a_r7_parked_not_ready: assert property (@(posedge clk) disable iff (rst)
        !tx_en |-> !tx_in_ready);

    a_r9_tx_hold: assert property (@(posedge clk) disable iff (rst)
        (tx_out_valid && !tx_out_ready && tx_en) |=>
            (tx_out_valid && $stable(tx_out_data) && $stable(tx_out_flag_n)));

    if (RX_PIPE) begin : g_rx_pipe
        a_r10_rx_hold: assert property (@(posedge clk) disable iff (rst)
            (rx_out_valid && !rx_out_ready) |=> (rx_out_valid && $stable(rx_out_data)));
        a_r10_rx_stall_ready: assert property (@(posedge clk) disable iff (rst)
            (rx_out_valid && !rx_out_ready) |-> !rx_in_ready);
        a_r10_rx_latency: assert property (@(posedge clk) disable iff (rst)
            (rx_in_valid && rx_in_ready) |=> rx_out_valid);
    end
endmodule

bind dbi_codec dbi_codec_chk #(.RX_PIPE(RX_PIPE)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .tx_en         (tx_en),
    .tx_in_valid   (tx_in_valid),
    .tx_in_ready   (tx_in_ready),
    .tx_in_data    (tx_in_data),
    .tx_out_valid  (tx_out_valid),
    .tx_out_ready  (tx_out_ready),
    .tx_out_data   (tx_out_data),
    .tx_out_flag_n (tx_out_flag_n),
    .rx_in_valid   (rx_in_valid),
    .rx_in_ready   (rx_in_ready),
    .rx_out_valid  (rx_out_valid),
    .rx_out_ready  (rx_out_ready),
    .rx_out_data   (rx_out_data)
);

// File: tb/test_dbi_codec.sv
module test_dbi_codec;
    logic        clk = 1'b0;
    logic        rst;
    logic        tx_en;
    logic        tx_in_valid;
    logic        tx_in_ready;
    logic [63:0] tx_in_data;
    logic        tx_out_valid;
    logic        tx_out_ready;
    logic [63:0] tx_out_data;
    logic [3:0]  tx_out_flag_n;
    logic        rx_in_valid;
    logic        rx_in_ready;
    logic [63:0] rx_in_data;
    logic [3:0]  rx_in_flag_n;
    logic        rx_out_valid;
    logic        rx_out_ready;
    logic [63:0] rx_out_data;

    logic        loop;
    logic        b_tx_ready;
    logic        b_rx_valid;
    logic [63:0] b_rx_data;
    logic [3:0]  b_rx_flag;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    assign rx_in_valid  = loop ? tx_out_valid  : b_rx_valid;
    assign rx_in_data   = loop ? tx_out_data   : b_rx_data;
    assign rx_in_flag_n = loop ? tx_out_flag_n : b_rx_flag;
    assign tx_out_ready = loop ? rx_in_ready   : b_tx_ready;

    dbi_codec i_dbi_codec (
        .clk(clk), .rst(rst), .tx_en(tx_en),
        .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data),
        .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready),
        .tx_out_data(tx_out_data), .tx_out_flag_n(tx_out_flag_n),
        .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready),
        .rx_in_data(rx_in_data), .rx_in_flag_n(rx_in_flag_n),
        .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready), .rx_out_data(rx_out_data)
    );

    function automatic int zc16(logic [15:0] v);
        int n = 0;
        for (int b = 0; b < 16; b++) if (!v[b]) n++;
        return n;
    endfunction

    function automatic logic [3:0] exp_flags(logic [63:0] w);
        logic [3:0] f;
        for (int i = 0; i < 4; i++) f[i] = (zc16(w[16*i +: 16]) <= 8);
        return f;
    endfunction

    function automatic logic [63:0] exp_enc(logic [63:0] w);
        logic [63:0] e;
        for (int i = 0; i < 4; i++)
            e[16*i +: 16] = (zc16(w[16*i +: 16]) <= 8) ? w[16*i +: 16] : ~w[16*i +: 16];
        return e;
    endfunction

    function automatic logic [63:0] exp_dec(logic [63:0] w, logic [3:0] f);
        logic [63:0] d;
        for (int i = 0; i < 4; i++)
            d[16*i +: 16] = f[i] ? w[16*i +: 16] : ~w[16*i +: 16];
        return d;
    endfunction

    task automatic chk(bit ok, string tag, logic [67:0] act, logic [67:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Send one word through encoder and decoder in loopback, checking both ends.
    task automatic round_trip(logic [63:0] w, string tag);
        logic [3:0] ef;
        ef = exp_flags(w);
        @(negedge clk);
        tx_in_valid = 1'b1;
        tx_in_data  = w;
        @(negedge clk);
        tx_in_valid = 1'b0;
        chk(tx_out_valid == 1'b1, {tag, " R5 tx valid"}, 68'(tx_out_valid), 68'd1);
        chk({tx_out_flag_n, tx_out_data} == {ef, exp_enc(w)}, {tag, " R1 R2 R3 encode"},
            {tx_out_flag_n, tx_out_data}, {ef, exp_enc(w)});
        @(negedge clk);
        chk(rx_out_valid && rx_out_data == w, {tag, " R8 R10 round trip"},
            {3'b0, rx_out_valid, rx_out_data}, {4'b1, w});
        chk(!tx_out_valid && tx_out_flag_n == 4'hF && tx_out_data == '1, {tag, " R6 idle after"},
            {tx_out_flag_n, tx_out_data}, {4'hF, 64'hFFFF_FFFF_FFFF_FFFF});
    endtask

    initial begin
        rst = 1'b1; tx_en = 1'b1; tx_in_valid = 1'b0; tx_in_data = '0;
        loop = 1'b1; b_tx_ready = 1'b1; b_rx_valid = 1'b0; b_rx_data = '0; b_rx_flag = 4'hF;
        rx_out_ready = 1'b1;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!tx_out_valid && tx_out_flag_n == 4'hF && tx_out_data == '1 && !rx_out_valid,
            "R6 reset state", {tx_out_flag_n, tx_out_data}, {4'hF, 64'hFFFF_FFFF_FFFF_FFFF});
        rst = 1'b0;

        round_trip(64'h0, "all zeros");
        round_trip('1, "all ones");
        round_trip({4{16'h00FF}}, "eight zeros R3");
        round_trip({4{16'h007F}}, "nine zeros R2");
        round_trip({16'hFFFF, 16'h0000, 16'h00FF, 16'h007F}, "mixed lanes R1");
        round_trip({16'h007F, 16'hFFFF, 16'h0000, 16'hFF00}, "mixed lanes 2 R1");

        // R8: decoder alone with arbitrary flags
        loop = 1'b0;
        @(negedge clk);
        b_rx_valid = 1'b1; b_rx_data = 64'h1234_5678_9ABC_DEF0; b_rx_flag = 4'b0101;
        @(negedge clk);
        b_rx_valid = 1'b0;
        chk(rx_out_valid && rx_out_data == exp_dec(64'h1234_5678_9ABC_DEF0, 4'b0101),
            "R8 decode flags 0101", 68'(rx_out_data), 68'(exp_dec(64'h1234_5678_9ABC_DEF0, 4'b0101)));

        // R10: receive stall holds word and drops ready
        @(negedge clk);
        rx_out_ready = 1'b0;
        b_rx_valid = 1'b1; b_rx_data = 64'hAAAA_0000_5555_FFFF; b_rx_flag = 4'b1010;
        @(negedge clk);
        b_rx_data = 64'h0; b_rx_flag = 4'h0;
        chk(!rx_in_ready, "R10 ready low while held", 68'(rx_in_ready), 68'd0);
        @(negedge clk);
        chk(rx_out_valid && rx_out_data == exp_dec(64'hAAAA_0000_5555_FFFF, 4'b1010),
            "R10 held word stable", 68'(rx_out_data), 68'(exp_dec(64'hAAAA_0000_5555_FFFF, 4'b1010)));
        b_rx_valid = 1'b0;
        rx_out_ready = 1'b1;
        @(negedge clk);

        // R9: transmit stall holds word
        b_tx_ready = 1'b0;
        tx_in_valid = 1'b1; tx_in_data = 64'h0000_FFFF_0F0F_0001;
        @(negedge clk);
        tx_in_data = 64'hFFFF_FFFF_FFFF_FFFF;
        chk(!tx_in_ready, "R9 tx input ready low while held", 68'(tx_in_ready), 68'd0);
        @(negedge clk);
        @(negedge clk);
        chk(tx_out_valid && tx_out_data == exp_enc(64'h0000_FFFF_0F0F_0001)
            && tx_out_flag_n == exp_flags(64'h0000_FFFF_0F0F_0001),
            "R9 tx held word stable", {tx_out_flag_n, tx_out_data},
            {exp_flags(64'h0000_FFFF_0F0F_0001), exp_enc(64'h0000_FFFF_0F0F_0001)});
        tx_in_valid = 1'b0;
        b_tx_ready = 1'b1;
        @(negedge clk);

        // R7: parked transmitter
        tx_en = 1'b0;
        tx_in_valid = 1'b1; tx_in_data = 64'h0;
        #1;
        chk(!tx_in_ready, "R7 ready low when disabled", 68'(tx_in_ready), 68'd0);
        @(negedge clk);
        @(negedge clk);
        chk(!tx_out_valid && tx_out_flag_n == 4'hF && tx_out_data == '1,
            "R7 no word while disabled", {tx_out_flag_n, tx_out_data},
            {4'hF, 64'hFFFF_FFFF_FFFF_FFFF});
        tx_in_valid = 1'b0;
        tx_en = 1'b1;
        loop = 1'b1;

        // Random words, lanes biased toward the threshold
        for (int k = 0; k < 150; k++) begin
            logic [63:0] w;
            w = {$urandom, $urandom};
            for (int i = 0; i < 4; i++) begin
                int sel = $urandom_range(0, 3);
                if (sel == 0) w[16*i +: 16] = w[16*i +: 16] & {$urandom} [15:0];
                else if (sel == 1) w[16*i +: 16] = w[16*i +: 16] | {$urandom} [15:0];
            end
            round_trip(w, "random R2 R3");
        end

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog R5 actual=timeout expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule